// File: doc/BRIEF.md
# Self-Correcting Shift-Register Counter

This block is a short shift register whose first stage is fed by a function of the whole state vector. A build-time parameter selects one of three feedback variants. The first is a corrected one-hot ring. The second is a corrected twisted ring, which feeds back an inverted last stage and so cycles through twice as many states as it has bits. The third is an uncorrected one-hot ring, kept only as a reference for comparison. In the two corrected variants the feedback is shaped so that any state the flops may hold after power-up drains into the normal cycle within a few clocks. After that the counter stays in the normal cycle.

The counter advances on each clock where enable is high. A synchronous reset loads the start state of the selected variant. A flag shows whether the present state belongs to the normal cycle of that variant. Turning the states into individual decoded outputs is left to the logic around the block.

Top module: `shift_counter`

## Requirements
- R1: Bit 0 of `state` is the first stage. On every enabled clock without reset, bit i takes the old bit i-1 for i of 1 and above, and bit 0 takes the feedback value of the selected variant.
- R2: A clock with `rst` high loads the start state, whatever `en` is. Both ring variants load bit 0 high and all other bits low (vector 4'b0001). The twisted ring loads all zeros.
- R3: A clock with `rst` low and `en` low leaves `state` unchanged.
- R4: In the corrected ring, the feedback is 1 exactly when bits 0 to WIDTH-2 are all zero. From reset, `state` steps through 4'b0001, 4'b0010, 4'b0100, 4'b1000 and back to 4'b0001.
- R5: In the corrected twisted ring, the feedback is NOT bit[WIDTH-1] AND (NOT bit[WIDTH-2] OR bit 0). From reset the vector steps through 4'b0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 and back to 4'b0000.
- R6: `valid` depends only on the present `state`. In both ring variants it is high exactly when a single bit is set. In the twisted ring it is high exactly for the eight vectors listed in R5.
- R7: With WIDTH 4 and `en` held high, starting from any of the 16 states, the corrected ring shows `valid` after at most 3 clocks and the corrected twisted ring after at most 5. Once `valid` is high in a corrected variant, it stays high on every following enabled clock.
- R8: The uncorrected ring feeds bit[WIDTH-1] back into bit 0. It therefore rotates any state without change to its number of set bits, so a state that does not hold exactly one set bit never raises `valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset to the start state, high active |
| en | input | 1 | Advance the counter by one step |
| state | output | WIDTH | Stage outputs; bit 0 is the first stage |
| valid | output | 1 | High while the state is in the normal cycle |

## Verification
The bench builds three copies at WIDTH 4, one for each feedback variant. The same reset, hold and enable stimulus is applied to all three side by side. This brings every one of the sixteen possible 4-bit states within reach of each variant. Each state is placed in the flops to stand in for a power-up value. The bench then counts the enabled clocks until the corrected variants show the valid flag, and confirms that the uncorrected ring keeps rotating wrong states forever.

// File: rtl/shift_counter_pkg.sv
package shift_counter_pkg;

  typedef enum logic [1:0] {
    MODE_RING_FIX    = 2'd0,
    MODE_JOHNSON_FIX = 2'd1,
    MODE_RING_PLAIN  = 2'd2
  } cnt_mode_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic feedIn;
  } ctrl_strobe_t;

endpackage

// File: rtl/sc_control.sv
module sc_control
  import shift_counter_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = MODE_RING_FIX
) (
  input  logic               rst,
  input  logic               en,
  input  logic [WIDTH-1:0]   stateQ,
  output ctrl_strobe_t       strobes,
  output logic               validOut
);

  localparam int CW = $clog2(WIDTH) + 1;

  logic feedBit;

  generate
    if (MODE == MODE_RING_FIX) begin : gFeedRing
      assign feedBit = ~|stateQ[WIDTH-2:0];
    end else if (MODE == MODE_JOHNSON_FIX) begin : gFeedJohnson
      assign feedBit = ~stateQ[WIDTH-1] & (~stateQ[WIDTH-2] | stateQ[0]);
    end else begin : gFeedPlain
      assign feedBit = stateQ[WIDTH-1];
    end
  endgenerate

  generate
    if (MODE == MODE_JOHNSON_FIX) begin : gValidJohnson
      logic [CW-1:0] edgeCount;
      always_comb begin
        edgeCount = '0;
        for (int i = 1; i < WIDTH; i++) begin
          edgeCount = edgeCount + {{(CW-1){1'b0}}, stateQ[i] ^ stateQ[i-1]};
        end
      end
      assign validOut = (edgeCount <= CW'(1));
    end else begin : gValidRing
      assign validOut = $onehot(stateQ);
    end
  endgenerate

  always_comb begin
    strobes.load   = rst;
    strobes.shift  = en & ~rst;
    strobes.feedIn = feedBit;
  end

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import shift_counter_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = MODE_RING_FIX
) (
  input  logic             clk,
  input  ctrl_strobe_t     strobes,
  output logic [WIDTH-1:0] stateQ
);

  localparam logic [WIDTH-1:0] RING_START = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] START_VAL  =
    (MODE == MODE_JOHNSON_FIX) ? '0 : RING_START;

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      stateQ <= START_VAL;
    end else if (strobes.shift) begin
      stateQ <= {stateQ[WIDTH-2:0], strobes.feedIn};
    end
  end

endmodule

// File: rtl/shift_counter.sv
module shift_counter
  import shift_counter_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = MODE_RING_FIX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] state,
  output logic             valid
);

  ctrl_strobe_t     strobes;
  logic [WIDTH-1:0] stateQ;

  sc_control #(.WIDTH(WIDTH), .MODE(MODE)) uCtrl (
    .rst      (rst),
    .en       (en),
    .stateQ   (stateQ),
    .strobes  (strobes),
    .validOut (valid)
  );

  sc_datapath #(.WIDTH(WIDTH), .MODE(MODE)) uData (
    .clk     (clk),
    .strobes (strobes),
    .stateQ  (stateQ)
  );

  assign state = stateQ;

endmodule

// File: rtl/sc_checker.sv
module sc_checker
  import shift_counter_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = MODE_RING_FIX
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] state,
  input logic             valid
);

  localparam logic [WIDTH-1:0] START_VAL =
    (MODE == MODE_JOHNSON_FIX) ? '0 : {{(WIDTH-1){1'b0}}, 1'b1};
  localparam int LIMIT = (MODE == MODE_JOHNSON_FIX) ? 2 * WIDTH : WIDTH;

  logic [7:0] badRun;

  always_ff @(posedge clk) begin
    if (rst || valid) begin
      badRun <= '0;
    end else if (en && badRun != 8'hFF) begin
      badRun <= badRun + 8'd1;
    end
  end

  // R2
  a_r2_reset_load: assert property (@(posedge clk) rst |=> state == START_VAL);

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

  // R1
  a_r1_shift: assert property (@(posedge clk) disable iff (rst)
    en |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));

  generate
    if (MODE == MODE_RING_PLAIN) begin : gPlain
      // R8
      a_r8_ones_kept: assert property (@(posedge clk) disable iff (rst)
        en |=> $countones(state) == $countones($past(state)));
    end else begin : gFixed
      // R7
      a_r7_stays_valid: assert property (@(posedge clk) disable iff (rst)
        (valid && en) |=> valid);
      // R7
      a_r7_bounded: assert property (@(posedge clk) disable iff (rst)
        badRun <= 8'(LIMIT));
    end
    if (MODE != MODE_JOHNSON_FIX) begin : gRingValid
      // R6
      a_r6_ring_valid: assert property (@(posedge clk) disable iff (rst)
        valid == $onehot(state));
    end
  endgenerate

endmodule

bind shift_counter sc_checker #(.WIDTH(WIDTH), .MODE(MODE)) uChk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .state (state),
  .valid (valid)
);

// File: tb/tb_shift_counter.sv
module tb_shift_counter;
  import shift_counter_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int         unit;
    logic [3:0] st;
    logic       vld;
    string      tag;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;

  logic [3:0] stO [3];
  logic       vldO [3];
  logic [3:0] model [3];

  exp_item_t expQ [$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_counter #(.WIDTH(4), .MODE(MODE_RING_FIX)) dut (
    .clk(clk), .rst(rst), .en(en), .state(stO[0]), .valid(vldO[0]));
  shift_counter #(.WIDTH(4), .MODE(MODE_JOHNSON_FIX)) dutJohnson (
    .clk(clk), .rst(rst), .en(en), .state(stO[1]), .valid(vldO[1]));
  shift_counter #(.WIDTH(4), .MODE(MODE_RING_PLAIN)) dutPlain (
    .clk(clk), .rst(rst), .en(en), .state(stO[2]), .valid(vldO[2]));

  function automatic logic [3:0] nextOf(int unit, logic [3:0] s);
    case (unit)
      0:       return {s[2:0], ~|s[2:0]};
      1:       return {s[2:0], ~s[3] & (~s[2] | s[0])};
      default: return {s[2:0], s[3]};
    endcase
  endfunction

  function automatic logic validOf(int unit, logic [3:0] s);
    if (unit == 1) begin
      return s inside {4'b0000, 4'b0001, 4'b0011, 4'b0111,
                       4'b1111, 4'b1110, 4'b1100, 4'b1000};
    end
    return $countones(s) == 1;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // driver: set inputs, predict, push expectations, wait for the edge
  task automatic cycle(logic r, logic e, string tag);
    @(negedge clk);
    rst = r;
    en  = e;
    for (int u = 0; u < 3; u++) begin
      exp_item_t it;
      if (r) model[u] = (u == 1) ? 4'b0000 : 4'b0001;
      else if (e) model[u] = nextOf(u, model[u]);
      it.unit = u;
      it.st   = model[u];
      it.vld  = validOf(u, model[u]);
      it.tag  = tag;
      expQ.push_back(it);
    end
    @(posedge clk);
    #1;
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (expQ.size() > 0) begin
        exp_item_t it;
        it = expQ.pop_front();
        check(stO[it.unit] == it.st, it.tag,
              $sformatf("state unit%0d", it.unit), stO[it.unit], it.st);
        check(vldO[it.unit] == it.vld, it.tag,
              $sformatf("valid unit%0d", it.unit), vldO[it.unit], it.vld);
      end
    end
  end

  task automatic seed(logic [3:0] s);
    @(negedge clk);
    $assertoff(0);
    rst = 1'b0;
    en  = 1'b0;
    force dut.uData.stateQ        = s;
    force dutJohnson.uData.stateQ = s;
    force dutPlain.uData.stateQ   = s;
    #1;
    release dut.uData.stateQ;
    release dutJohnson.uData.stateQ;
    release dutPlain.uData.stateQ;
    for (int u = 0; u < 3; u++) model[u] = s;
    @(posedge clk);
    @(negedge clk);
    $asserton(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 3; u++) model[u] = 4'b0000;
    // R2: reset, also with enable high
    cycle(1'b1, 1'b0, "R2");
    cycle(1'b1, 1'b1, "R2");
    // R3: hold
    repeat (3) cycle(1'b0, 1'b0, "R3");
    // R1 R4 R5 R6: free run across more than one full cycle
    repeat (10) cycle(1'b0, 1'b1, "R1_R4_R5_R6");
    // R3 hold mid-cycle, then resume
    repeat (2) cycle(1'b0, 1'b0, "R3");
    repeat (3) cycle(1'b0, 1'b1, "R1_R4_R5");
    // R2 reset in mid-run
    cycle(1'b1, 1'b1, "R2");
    repeat (2) cycle(1'b0, 1'b1, "R4_R5");

    // R7 R8: every 4-bit start state
    for (int s = 0; s < 16; s++) begin
      int firstValid [3];
      bit plainEver;
      seed(4'(s));
      for (int u = 0; u < 3; u++) firstValid[u] = validOf(u, 4'(s)) ? 0 : -1;
      plainEver = validOf(2, 4'(s));
      for (int k = 1; k <= 8; k++) begin
        cycle(1'b0, 1'b1, "R7_R8");
        for (int u = 0; u < 2; u++)
          if (firstValid[u] < 0 && vldO[u]) firstValid[u] = k;
        if (vldO[2]) plainEver = 1'b1;
      end
      check(firstValid[0] >= 0 && firstValid[0] <= 3, "R7",
            $sformatf("ring clocks to valid from %0h", s), firstValid[0], 3);
      check(firstValid[1] >= 0 && firstValid[1] <= 5, "R7",
            $sformatf("johnson clocks to valid from %0h", s), firstValid[1], 5);
      check(plainEver == ($countones(4'(s)) == 1), "R8",
            $sformatf("plain ring valid seen from %0h", s),
            plainEver, $countones(4'(s)) == 1);
    end

    cycle(1'b1, 1'b0, "R2");
    cycle(1'b0, 1'b1, "R4_R5");
    @(posedge clk);
    #(CLK_PERIOD/2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule